// File: doc/BRIEF.md
# Prioritized Maskable Interrupt Source Controller

This block gathers interrupt events from five groups: wake-up, supply and regulator monitoring, the LIN bus transceiver, the high-side drivers and the low-side drivers. Each source has a sticky pending flag. A four-bit enable register selects which groups may record events. The supply under-voltage, regulator over-temperature warning and wake-up sources are never gated. One active-low interrupt line tells the host that something is pending.

The host reads a four-bit source code. The code names the highest-priority pending source, and the read clears that source's flag. If other flags remain set, the interrupt line is released for a fixed number of clock cycles and then pulled low again, so each pending source is handed over in its own turn. A write to the enable register also returns the current source code, but acknowledges nothing. The serial transport is reduced to single-cycle read and write strobes.

Top module: `irq_source_ctrl`

## Requirements
- R1: After reset every enable bit is 1, no flag is pending, `irq_n` is 1 and `rd_data` is 0.
- R2: Event input bit k latches the pending flag of source k, whose source code is k+1. The bit assignments are: 0 local wake, 1 bus wake, 2 timed wake, 3 supply under-voltage, 4 regulator over-temperature warning, 5 supply over-voltage, 6 LIN fault, 7 high-side fault, 8 low-side fault. Code 0 means nothing is pending. `irq_n` goes low on the clock edge that latches the first flag.
- R3: When several flags are set, the code reported is the one of the lowest-numbered source. This places wake-up first, then the supply monitor, then LIN, then high side, then low side.
- R4: Enable bit 0 gates over-voltage, bit 1 gates LIN, bit 2 gates high side and bit 3 gates low side. An event in a group whose bit is 0 sets no flag and leaves `irq_n` high.
- R5: The under-voltage, regulator-warning and all wake-up events set their flags whatever the enable register holds.
- R6: A read strobe loads the current code into `rd_data` on the next edge and clears that source's flag. When no other flag remains, `irq_n` is high after that edge.
- R7: When flags remain after an acknowledge, `irq_n` stays high for exactly RELEASE_CYC cycles after the acknowledging edge and then goes low.
- R8: A write strobe loads `wr_data` into the enable register and the current code into `rd_data`. It clears no flag.
- R9: An event for the source being acknowledged, arriving in the same cycle as the read, leaves that flag set.
- R10: Repeated events of an already pending source need only one acknowledge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt | input | 9 | Event pulses or levels, one bit per source |
| rd_en | input | 1 | Read and acknowledge the source code |
| wr_en | input | 1 | Write the enable register |
| wr_data | input | 4 | Enable value for a write |
| rd_data | output | 4 | Source code returned by a read or a write |
| irq_n | output | 1 | Active-low interrupt request |

## Verification
An event applied before a clock edge sets its flag and pulls `irq_n` low on that same edge. The bench therefore drives inputs on the falling edge and checks `irq_n` on the next falling edge. `rd_data` changes on the edge that samples a read or write strobe. The monitor compares it against the scoreboard one falling edge after the strobe. For the release window, `irq_n` is sampled after the acknowledging edge, again after RELEASE_CYC-1 further edges where it must still be high, and once more one edge later where it must be low.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
  localparam int NSRC   = 9;
  localparam int CODE_W = 4;
  localparam int MASK_W = 4;

  // source index of each event input bit; code = index + 1
  localparam int SRC_WAKE_LOCAL = 0;
  localparam int SRC_WAKE_BUS   = 1;
  localparam int SRC_WAKE_TIMED = 2;
  localparam int SRC_SUP_UV     = 3;
  localparam int SRC_REG_OT     = 4;
  localparam int SRC_SUP_OV     = 5;
  localparam int SRC_LIN        = 6;
  localparam int SRC_HS         = 7;
  localparam int SRC_LS         = 8;

  // enable bit that gates a source, -1 when never gated
  function automatic int gate_bit(input int src);
    case (src)
      SRC_SUP_OV: return 0;
      SRC_LIN:    return 1;
      SRC_HS:     return 2;
      SRC_LS:     return 3;
      default:    return -1;
    endcase
  endfunction
endpackage

// File: rtl/irqc_rst_sync.sv
module irqc_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= 2'b00;
    else        stage_q <= {stage_q[0], 1'b1};
  end

  assign rst_sync_n = stage_q[1];
endmodule

// File: rtl/irqc_mask_gate.sv
module irqc_mask_gate
  import irqc_pkg::*;
(
  input  logic [NSRC-1:0]   evt,
  input  logic [MASK_W-1:0] mask,
  output logic [NSRC-1:0]   set_vec
);
  for (genvar s = 0; s < NSRC; s++) begin : g_src
    localparam int GB = gate_bit(s);
    if (GB < 0) begin : g_open
      assign set_vec[s] = evt[s];
    end else begin : g_gated
      assign set_vec[s] = evt[s] & mask[GB];
    end
  end
endmodule

// File: rtl/irqc_prio_enc.sv
module irqc_prio_enc
  import irqc_pkg::*;
(
  input  logic [NSRC-1:0]   pend,
  output logic [CODE_W-1:0] code,
  output logic [NSRC-1:0]   sel
);
  always_comb begin
    code = '0;
    sel  = '0;
    for (int s = NSRC - 1; s >= 0; s--) begin
      if (pend[s]) begin
        code = CODE_W'(s + 1);
        sel  = NSRC'(1) << s;
      end
    end
  end
endmodule

// File: rtl/irqc_release_timer.sv
module irqc_release_timer #(
  parameter int RELEASE_CYC = 1000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic busy_next
);
  localparam int CNT_W = $clog2(RELEASE_CYC + 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (start)              cnt_d = CNT_W'(RELEASE_CYC);
    else if (cnt_q != '0)   cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign busy_next = (cnt_d != '0);
endmodule

// File: rtl/irq_source_ctrl.sv
module irq_source_ctrl
  import irqc_pkg::*;
#(
  parameter int RELEASE_CYC = 1000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NSRC-1:0]   evt,
  input  logic              rd_en,
  input  logic              wr_en,
  input  logic [MASK_W-1:0] wr_data,
  output logic [CODE_W-1:0] rd_data,
  output logic              irq_n
);
  logic              rst_sync_n;
  logic [MASK_W-1:0] mask_q, mask_d;
  logic [NSRC-1:0]   pend_q, pend_d, set_vec, sel;
  logic [CODE_W-1:0] cur_code, rd_q, rd_d;
  logic              irq_q, irq_d, ack, gap_next;

  irqc_rst_sync u_rst (.clk(clk), .rst_n(rst_n), .rst_sync_n(rst_sync_n));

  irqc_mask_gate u_gate (.evt(evt), .mask(mask_q), .set_vec(set_vec));

  irqc_prio_enc u_enc (.pend(pend_q), .code(cur_code), .sel(sel));

  assign ack = rd_en && (cur_code != '0);

  irqc_release_timer #(.RELEASE_CYC(RELEASE_CYC)) u_tmr (
    .clk(clk), .rst_n(rst_sync_n),
    .start(ack && (pend_d != '0)),
    .busy_next(gap_next)
  );

  always_comb begin
    mask_d = mask_q;
    if (wr_en) mask_d = wr_data;

    pend_d = (pend_q & ~(ack ? sel : '0)) | set_vec;

    rd_d = rd_q;
    if (rd_en || wr_en) rd_d = cur_code;

    irq_d = !((pend_d != '0) && !gap_next);
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      mask_q <= '1;
      pend_q <= '0;
      rd_q   <= '0;
      irq_q  <= 1'b1;
    end else begin
      mask_q <= mask_d;
      pend_q <= pend_d;
      rd_q   <= rd_d;
      irq_q  <= irq_d;
    end
  end

  assign rd_data = rd_q;
  assign irq_n   = irq_q;
endmodule

// File: rtl/irq_source_ctrl_chk.sv
module irq_source_ctrl_chk
  import irqc_pkg::*;
#(
  parameter int RELEASE_CYC = 1000
) (
  input logic              clk,
  input logic              rst_sync_n,
  input logic [NSRC-1:0]   evt,
  input logic              rd_en,
  input logic              wr_en,
  input logic [MASK_W-1:0] wr_data,
  input logic [CODE_W-1:0] rd_data,
  input logic              irq_n,
  input logic [MASK_W-1:0] mask_q,
  input logic [NSRC-1:0]   pend_q,
  input logic [CODE_W-1:0] cur_code
);
  localparam int HW = $clog2(RELEASE_CYC + 2) + 1;
  logic [HW-1:0] hi_cnt;

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n)                         hi_cnt <= '0;
    else if (rd_en || !irq_n || pend_q == '0) hi_cnt <= '0;
    else                                     hi_cnt <= hi_cnt + 1'b1;
  end

  assert_reset_idle_R1: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (pend_q == '0) |-> irq_n);

  assert_low_means_pending_R2: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !irq_n |-> (pend_q != '0));

  assert_code_returned_R6: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (rd_en || wr_en) |=> (rd_data == $past(cur_code)));

  assert_masked_ignored_R4: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (evt[SRC_HS] && !mask_q[2] && !pend_q[SRC_HS] && !rd_en) |=> !pend_q[SRC_HS]);

  assert_unmaskable_R5: assert property (@(posedge clk) disable iff (!rst_sync_n)
    evt[SRC_SUP_UV] |=> pend_q[SRC_SUP_UV]);

  assert_mask_write_R8: assert property (@(posedge clk) disable iff (!rst_sync_n)
    wr_en |=> (mask_q == $past(wr_data)));

  assert_release_bounded_R7: assert property (@(posedge clk) disable iff (!rst_sync_n)
    hi_cnt <= HW'(RELEASE_CYC));
endmodule

bind irq_source_ctrl irq_source_ctrl_chk #(.RELEASE_CYC(RELEASE_CYC)) u_chk (
  .clk(clk), .rst_sync_n(rst_sync_n), .evt(evt), .rd_en(rd_en), .wr_en(wr_en),
  .wr_data(wr_data), .rd_data(rd_data), .irq_n(irq_n), .mask_q(mask_q),
  .pend_q(pend_q), .cur_code(cur_code)
);

// File: tb/irq_source_ctrl_test.sv
module irq_source_ctrl_test;
  localparam int REL = 40;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [8:0] evt = '0;
  logic       rd_en = 1'b0, wr_en = 1'b0;
  logic [3:0] wr_data = '0;
  logic [3:0] rd_data;
  logic       irq_n;

  int checks = 0, errors = 0;
  bit strobe_seen = 1'b0;
  logic [3:0] exp_q[$];
  string      tag_q[$];

  irq_source_ctrl #(.RELEASE_CYC(REL)) uut (
    .clk(clk), .rst_n(rst_n), .evt(evt), .rd_en(rd_en), .wr_en(wr_en),
    .wr_data(wr_data), .rd_data(rd_data), .irq_n(irq_n)
  );

  always #5 clk = ~clk;

  always @(posedge clk) strobe_seen <= rd_en | wr_en;

  // monitor: compare rd_data after each strobe against the scoreboard
  always @(negedge clk) begin
    if (strobe_seen && exp_q.size() != 0) begin
      logic [3:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      checks++;
      if (rd_data !== e) begin
        errors++;
        $display("FAIL %s rd_data actual %0d expected %0d", t, rd_data, e);
      end
    end
  end

  task automatic chk_irq(input logic exp, input string t);
    checks++;
    if (irq_n !== exp) begin
      errors++;
      $display("FAIL %s irq_n actual %0b expected %0b", t, irq_n, exp);
    end
  endtask

  task automatic step(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic pulse(input logic [8:0] v);
    evt = v;
    @(negedge clk);
    evt = '0;
  endtask

  task automatic do_read(input logic [3:0] exp, input string t);
    exp_q.push_back(exp);
    tag_q.push_back(t);
    rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic do_write(input logic [3:0] m, input logic [3:0] exp, input string t);
    exp_q.push_back(exp);
    tag_q.push_back(t);
    wr_en = 1'b1;
    wr_data = m;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  initial begin
    fork
      begin : wd
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
      end
      begin : body
        step(2);
        rst_n = 1'b1;
        step(4);
        // R1 reset state
        chk_irq(1'b1, "R1");
        do_read(4'd0, "R1");
        step(1);
        chk_irq(1'b1, "R1");

        // R2 single high-side event, R6 acknowledge
        pulse(9'h080);
        chk_irq(1'b0, "R2");
        do_read(4'd8, "R2");
        chk_irq(1'b1, "R6");
        do_read(4'd0, "R6");
        step(1);

        // R3 priority and R7 release window
        pulse(9'h142); // bus wake, LIN, low side
        chk_irq(1'b0, "R3");
        do_read(4'd2, "R3");
        chk_irq(1'b1, "R7");
        step(REL - 1);
        chk_irq(1'b1, "R7");
        step(1);
        chk_irq(1'b0, "R7");
        do_read(4'd7, "R3");
        step(REL + 1);
        do_read(4'd9, "R3");
        chk_irq(1'b1, "R6");
        step(2);

        // R4 all gated groups disabled
        do_write(4'h0, 4'd0, "R8");
        pulse(9'h1E0); // over-voltage, LIN, high side, low side
        step(1);
        chk_irq(1'b1, "R4");
        do_read(4'd0, "R4");
        // R5 ungated sources
        pulse(9'h018); // under-voltage, regulator warning
        chk_irq(1'b0, "R5");
        do_read(4'd4, "R5");
        step(REL + 1);
        do_read(4'd5, "R5");
        pulse(9'h004);
        do_read(4'd3, "R5");
        step(1);
        // R8 write returns code without acknowledging
        do_write(4'hF, 4'd0, "R8");
        pulse(9'h080);
        do_write(4'hF, 4'd8, "R8");
        chk_irq(1'b0, "R8");
        do_read(4'd8, "R8");
        chk_irq(1'b1, "R8");
        step(1);

        // R9 event in acknowledge cycle
        pulse(9'h080);
        evt = 9'h080;
        do_read(4'd8, "R9");
        evt = '0;
        chk_irq(1'b1, "R9");
        step(REL);
        chk_irq(1'b0, "R9");
        do_read(4'd8, "R9");
        step(1);

        // R10 duplicate events collapse
        pulse(9'h100);
        pulse(9'h100);
        do_read(4'd9, "R10");
        chk_irq(1'b1, "R10");
        do_read(4'd0, "R10");
        step(2);
        disable wd;
      end
    join
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule